// File: doc/BRIEF.md
# GPIO Interrupt Cause Controller

This block gathers interrupt requests from 32 general-purpose input lines and hands them to a main interrupt controller as four grouped request lines. Each raw line is first synchronised to the core clock. It then passes through a per-pin inversion stage, and the result is the pin's input data value. Software can read that value through the register bus.

The input data value feeds two paths. The level path treats the data value itself as the cause and gates it with a per-pin level enable. The edge path records each rising transition of the data value in a sticky cause bit. That bit stays set until software clears it, and it is gated by a per-pin edge enable. Because both paths sit after the inversion stage, inverting a pin chooses active-low level or falling-edge sensing. Flipping a pin's inversion bit after each event gives sensing on both edges.

Pins whose direction bit marks them as outputs never raise a cause. Each group of eight neighbouring pins merges its enabled causes into one registered request output. The registers sit on a single-cycle write bus with a combinational read.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the direction register reads 0xFFFFFFFF (every pin an input). The polarity, edge-cause, edge-enable and level-enable registers read 0, and every group request is low.
- R2: The data-in register (byte offset 0x08) reads each pin's synchronised line value XOR its polarity bit (offset 0x04). A pin change is visible two clocks after it is sampled.
- R3: A pin whose data-in bit is 1, whose level-enable bit (offset 0x14) is 1 and whose direction bit (offset 0x00) is 1 drives its group request high on the next clock.
- R4: A 0-to-1 change of a pin's data-in bit, compared with its value one clock earlier, sets that pin's bit in the edge-cause register (offset 0x0C). The bit stays set after the line returns to 0.
- R5: A write to the edge-cause register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R6: When a new edge and a clearing write hit the same bit in the same clock, the bit ends up set.
- R7: Changing a polarity bit so that the data-in bit goes from 0 to 1 counts as an edge, just as a line change does.
- R8: A pin whose direction bit is 0 (output) sets no edge-cause bit and raises no level cause. Its data-in bit can still be read.
- R9: Group request bit g is the registered OR of the enabled level and edge causes of pins 8g to 8g+7, and of no other pins.
- R10: An edge-cause bit whose edge-enable bit (offset 0x10) is 0 can still be read as set, but it does not drive any group request.
- R11: The direction, polarity and enable registers read back the values written to them. Writes to the data-in register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Raw asynchronous GPIO lines |
| bus_we | input | 1 | Register write strobe, one write per clock |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| irq_grp | output | 4 | Registered request, one per group of eight pins |

## Verification
The bench times a line edge so that it reaches the edge-cause register in the same clock as a clearing write. A design that gives priority to the write would lose that event. It flips polarity bits with the lines held still. A detector that looks at raw lines instead of the inverted data would miss those edges, which breaks sensing on both edges. It sets a cause on pin 17 and expects only the third group request to rise. A wrong slice of the cause vector would light a neighbouring group. Last, it drives a pin configured as an output, and it lets an edge cause sit set while its enable is off. A design that forgets the direction gate or the enable would raise a request that should not exist.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned NUM_PINS   = 32;
    localparam int unsigned GROUP_SIZE = 8;
    localparam int unsigned NUM_GROUPS = NUM_PINS / GROUP_SIZE;
    localparam int unsigned ADDR_W     = 5;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DIR   = 5'h00,
        OFS_POL   = 5'h04,
        OFS_DIN   = 5'h08,
        OFS_ECAU  = 5'h0C,
        OFS_EMSK  = 5'h10,
        OFS_LMSK  = 5'h14
    } reg_ofs_e;

    typedef struct packed {
        logic dir;
        logic pol;
        logic ecau;
        logic emsk;
        logic lmsk;
    } wr_sel_t;

    function automatic wr_sel_t decode_write(input logic we, input logic [ADDR_W-1:0] a);
        wr_sel_t s;
        s.dir  = we && (a == OFS_DIR);
        s.pol  = we && (a == OFS_POL);
        s.ecau = we && (a == OFS_ECAU);
        s.emsk = we && (a == OFS_EMSK);
        s.lmsk = we && (a == OFS_LMSK);
        return s;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] data_in,
    input  logic [WIDTH-1:0] in_en,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_keep,
    output logic [WIDTH-1:0] cause_q
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] kept;

    always_comb begin
        rise = data_in & ~prev_q & in_en;
        kept = clr_we ? (cause_q & clr_keep) : cause_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            cause_q <= '0;
        end else begin
            prev_q  <= data_in;
            cause_q <= kept | rise;
        end
    end
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned GROUP = 8,
    localparam int unsigned NGRP = WIDTH / GROUP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_on,
    input  logic [WIDTH-1:0] edge_on,
    output logic [NGRP-1:0]  grp_q
);
    logic [WIDTH-1:0] any_on;
    assign any_on = level_on | edge_on;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst) grp_q[g] <= 1'b0;
            else     grp_q[g] <= |any_on[g*GROUP +: GROUP];
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_PINS  = NUM_PINS,
    parameter int unsigned GRP_SZ  = GROUP_SIZE,
    parameter int unsigned N_SYNC  = SYNC_DEPTH,
    localparam int unsigned N_GRP  = N_PINS / GRP_SZ
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    output logic [N_GRP-1:0]  irq_grp
);
    logic [N_PINS-1:0] dir_q, pol_q, emsk_q, lmsk_q;
    logic [N_PINS-1:0] pin_sync, data_in, edge_cause_q;
    logic [N_PINS-1:0] level_on, edge_on;
    wr_sel_t           wsel;

    assign wsel = decode_write(bus_we, bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '1;
            pol_q  <= '0;
            emsk_q <= '0;
            lmsk_q <= '0;
        end else begin
            if (wsel.dir)  dir_q  <= bus_wdata;
            if (wsel.pol)  pol_q  <= bus_wdata;
            if (wsel.emsk) emsk_q <= bus_wdata;
            if (wsel.lmsk) lmsk_q <= bus_wdata;
        end
    end

    gpio_irq_sync #(.WIDTH(N_PINS), .STAGES(N_SYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    assign data_in = pin_sync ^ pol_q;

    gpio_irq_edge #(.WIDTH(N_PINS)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .data_in  (data_in),
        .in_en    (dir_q),
        .clr_we   (wsel.ecau),
        .clr_keep (bus_wdata),
        .cause_q  (edge_cause_q)
    );

    assign level_on = data_in & lmsk_q & dir_q;
    assign edge_on  = edge_cause_q & emsk_q;

    gpio_irq_merge #(.WIDTH(N_PINS), .GROUP(GRP_SZ)) u_merge (
        .clk      (clk),
        .rst      (rst),
        .level_on (level_on),
        .edge_on  (edge_on),
        .grp_q    (irq_grp)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_DIR:  bus_rdata = dir_q;
            OFS_POL:  bus_rdata = pol_q;
            OFS_DIN:  bus_rdata = data_in;
            OFS_ECAU: bus_rdata = edge_cause_q;
            OFS_EMSK: bus_rdata = emsk_q;
            OFS_LMSK: bus_rdata = lmsk_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_PINS = NUM_PINS,
    parameter int unsigned N_GRP  = NUM_GROUPS
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N_PINS-1:0] ecause,
    input logic [N_PINS-1:0] dir,
    input logic [N_PINS-1:0] din,
    input logic [N_PINS-1:0] lmsk,
    input logic [N_PINS-1:0] emsk,
    input logic [N_GRP-1:0]  irq
);
    // R4: without a write to the edge-cause register no set bit drops
    a_r4_sticky_cause: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == OFS_ECAU) |=> ((ecause & $past(ecause)) == $past(ecause)));

    // R8: a newly set cause bit always belongs to a pin that was an input
    a_r8_no_output_cause: assert property (@(posedge clk) disable iff (rst)
        (dir != '1) |=> ((ecause & ~$past(ecause) & ~$past(dir)) == '0));

    // R9: with no enabled cause anywhere, all requests are low next clock
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (((din & lmsk & dir) | (ecause & emsk)) == '0) |=> (irq == '0));

    // R3: an enabled level cause always produces a request next clock
    a_r3_level_raises: assert property (@(posedge clk) disable iff (rst)
        ((din & lmsk & dir) != '0) |=> (irq != '0));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.N_PINS(N_PINS), .N_GRP(N_GRP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .ecause   (edge_cause_q),
    .dir      (dir_q),
    .din      (data_in),
    .lmsk     (lmsk_q),
    .emsk     (emsk_q),
    .irq      (irq_grp)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
    import gpio_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pin_in = '0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_grp;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    gpio_irq_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pin_in),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_grp   (irq_grp)
    );

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = it.is_irq ? {28'd0, irq_grp} : bus_rdata;
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic chk_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        sb.push_back('{is_irq: 1'b0, exp: e, tag: tag});
        @(negedge clk); #1;
    endtask

    task automatic chk_irq(input logic [3:0] e, input string tag);
        @(posedge clk); #1;
        sb.push_back('{is_irq: 1'b1, exp: {28'd0, e}, tag: tag});
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        settle(3); #1; rst = 1'b0;

        chk_rd(OFS_DIR,  32'hFFFF_FFFF, "R1 dir reset");
        chk_rd(OFS_POL,  32'h0, "R1 pol reset");
        chk_rd(OFS_ECAU, 32'h0, "R1 ecause reset");
        chk_rd(OFS_EMSK, 32'h0, "R1 emask reset");
        chk_rd(OFS_LMSK, 32'h0, "R1 lmask reset");
        chk_irq(4'h0, "R1 irq reset");

        pin_in = 32'h0000_00A5; settle(4);
        chk_rd(OFS_DIN,  32'h0000_00A5, "R2 data-in plain");
        chk_rd(OFS_ECAU, 32'h0000_00A5, "R4 rising lines latched");
        chk_irq(4'h0, "R10 edge causes not enabled");

        wr(OFS_POL, 32'h0000_00FF); settle(4);
        chk_rd(OFS_DIN,  32'h0000_005A, "R2 data-in inverted");
        chk_rd(OFS_ECAU, 32'h0000_00FF, "R7 polarity flip edge");
        wr(OFS_ECAU, 32'h0);
        chk_rd(OFS_ECAU, 32'h0, "R5 clear all");

        wr(OFS_POL, 32'h0); settle(4);
        chk_rd(OFS_ECAU, 32'h0000_00A5, "R7 polarity restore edge");
        wr(OFS_ECAU, 32'hFFFF_FFF0);
        chk_rd(OFS_ECAU, 32'h0000_00A0, "R5 ones keep zeros clear");
        wr(OFS_ECAU, 32'h0);

        wr(OFS_LMSK, 32'h1); settle(2);
        chk_irq(4'h1, "R3 level cause group0");
        chk_rd(OFS_LMSK, 32'h1, "R11 lmask readback");
        wr(OFS_DIR, 32'hFFFF_FFFE); settle(2);
        chk_irq(4'h0, "R8 output pin no level cause");
        chk_rd(OFS_DIR, 32'hFFFF_FFFE, "R11 dir readback");
        wr(OFS_DIR, 32'hFFFF_FFFF);
        wr(OFS_LMSK, 32'h0);

        pin_in = 32'h0; settle(4);
        wr(OFS_ECAU, 32'h0);
        chk_rd(OFS_ECAU, 32'h0, "R4 falling lines set nothing");

        wr(OFS_EMSK, 32'h0002_0000);
        pin_in = 32'h0002_0000; settle(4);
        chk_rd(OFS_ECAU, 32'h0002_0000, "R4 pin17 edge");
        chk_irq(4'b0100, "R9 pin17 drives group2 only");
        pin_in = 32'h0; settle(4);
        chk_rd(OFS_ECAU, 32'h0002_0000, "R4 sticky after line low");
        chk_irq(4'b0100, "R4 request held while cause set");
        wr(OFS_ECAU, 32'h0); settle(2);
        chk_irq(4'h0, "R5 request drops after clear");

        pin_in = 32'h4000_0000; settle(4);
        chk_rd(OFS_ECAU, 32'h4000_0000, "R10 unmasked cause readable");
        chk_irq(4'h0, "R10 disabled edge no request");
        wr(OFS_ECAU, 32'h0);

        wr(OFS_DIR, 32'hFFFF_FDFF);
        pin_in = 32'h4000_0200; settle(4);
        chk_rd(OFS_ECAU, 32'h0, "R8 output pin no edge");
        chk_rd(OFS_DIN, 32'h4000_0200, "R8 output pin data readable");
        wr(OFS_DIR, 32'hFFFF_FFFF); settle(2);
        chk_rd(OFS_ECAU, 32'h0, "R8 no late edge on dir change");

        // R6: edge reaches the cause register on the same clock as a clear
        @(posedge clk); #1;
        pin_in = 32'h4000_0210;
        @(posedge clk);
        wr(OFS_ECAU, 32'h0);
        chk_rd(OFS_ECAU, 32'h0000_0010, "R6 edge beats clear");

        wr(OFS_DIN, 32'h1234_5678);
        chk_rd(OFS_DIN, 32'h4000_0210, "R11 data-in write ignored");
        wr(OFS_EMSK, 32'h0F0F_0000);
        chk_rd(OFS_EMSK, 32'h0F0F_0000, "R11 emask readback");
        wr(OFS_POL, 32'h8000_0001);
        chk_rd(OFS_POL, 32'h8000_0001, "R11 pol readback");

        settle(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule